// File: doc/BRIEF.md
# RGB Panel Video Timing Generator

This block produces the raster timing for a parallel RGB display panel: horizontal sync, vertical sync, data enable, a pixel clock output and a one-cycle pixel enable for the pixel pipeline that feeds the panel. Software programs the sync width, back porch, active size and front porch for each axis. Each of these values is written as its length minus one. A divider on the source clock sets the pixel rate. Every output can have its polarity inverted.

All configuration inputs go to a shadow set. The running set takes the shadow values only at a frame boundary, which is the cycle in which the counters wrap to the start of vertical sync. While the block is stopped, it takes them at once. A hold input keeps the running set frozen across boundaries, so that a multi-field update is never applied half-written. A frame interrupt pulses once per frame at a selectable point. Clearing the enable lets the frame in progress finish, and the outputs go idle at the next boundary.

Top module: `vid_timing_gen`

## Requirements
- R1: A line lasts (hsync_w+1)+(hback+1)+(hactive+1)+(hfront+1) pixels, in the order sync, back porch, active, front porch. Horizontal sync is active for the first hsync_w+1 pixels of every line.
- R2: A frame lasts (vsync_w+1)+(vback+1)+(vactive+1)+(vfront+1) lines, in the same order. Vertical sync is active for the first vsync_w+1 lines, and it becomes active in the first cycle of pixel (0,0).
- R3: Data enable is active only when both counters are inside their active regions. That gives exactly (hactive+1)*(vactive+1) pixels per frame.
- R4: The pixel position advances once every clk_div+1 source clocks, and pix_en pulses in the last cycle of each pixel. The raw pixel clock is high during the last clk_div-(clk_div>>1) cycles of each pixel, so it stays low when clk_div is 0.
- R5: The four invert inputs (vsync, hsync, data enable, pixel clock) each flip the level of their own output. The idle level of every output is its inactive level XOR its invert bit.
- R6: Configuration changes made while the generator runs and the hold input is low take effect at the next frame boundary. They never take effect in the middle of a frame.
- R7: While cfg_hold is high, no configuration is taken at a frame boundary. The pending values take effect at the first boundary after cfg_hold falls.
- R8: Clearing cfg_en lets the current frame complete. After that, sync and data enable stay inactive and pix_en stays low. Setting cfg_en while the generator is stopped starts a frame on the next cycle.
- R9: frame_irq is a one-cycle pulse, issued once per frame, in the first cycle of the selected point. The select codes are 0 for the start of the vertical front porch, 1 for the start of vertical sync, 2 for the start of the vertical back porch and 3 for the first active line.
- R10: After reset, every output is low and the generator is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Video enable (shadowed) |
| cfg_hold | input | 1 | Hold off loading of the shadow set |
| cfg_irq_sel | input | 2 | Frame interrupt point select (shadowed) |
| cfg_inv_vsync | input | 1 | Invert vertical sync |
| cfg_inv_hsync | input | 1 | Invert horizontal sync |
| cfg_inv_de | input | 1 | Invert data enable |
| cfg_inv_pclk | input | 1 | Invert pixel clock |
| cfg_clk_div | input | 8 | Pixel clock divide value minus one |
| cfg_hsync_w | input | 10 | Horizontal sync width minus one |
| cfg_hback | input | 10 | Horizontal back porch minus one |
| cfg_hactive | input | 10 | Active pixels per line minus one |
| cfg_hfront | input | 10 | Horizontal front porch minus one |
| cfg_vsync_w | input | 10 | Vertical sync width minus one |
| cfg_vback | input | 10 | Vertical back porch minus one |
| cfg_vactive | input | 10 | Active lines minus one |
| cfg_vfront | input | 10 | Vertical front porch minus one |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk | output | 1 | Pixel clock |
| pix_en | output | 1 | Pixel advance strobe |
| frame_irq | output | 1 | Frame interrupt pulse |

## Verification
A configuration load and the frame interrupt for "start of vertical sync" fall in the same cycle, because both are tied to the counter wrap. A disable that completes at that same wrap adds a third event to that cycle. The bench changes settings in the middle of a frame and also while the hold input is high. It then judges the whole frame period that follows, together with the interrupt offset from the vertical sync edge. A load that lands one cycle early or late shows up in those counts. An interrupt that is lost or doubled at the wrap also shows up.

// File: rtl/vtg_pkg.sv
// Shared widths and the configuration record of the video timing generator.
package vtg_pkg;
    localparam int unsigned FW = 10;      // width of each timing field
    localparam int unsigned DW = 8;       // width of the divider field
    localparam int unsigned CW = FW + 2;  // width of the position counters

    typedef enum logic [1:0] {
        IRQ_FRONT  = 2'd0,
        IRQ_SYNC   = 2'd1,
        IRQ_BACK   = 2'd2,
        IRQ_ACTIVE = 2'd3
    } irq_sel_e;

    typedef struct packed {
        logic          en;
        irq_sel_e      irq_sel;
        logic          inv_vs;
        logic          inv_hs;
        logic          inv_de;
        logic          inv_pclk;
        logic [DW-1:0] div;
        logic [FW-1:0] hspw;
        logic [FW-1:0] hbp;
        logic [FW-1:0] hact;
        logic [FW-1:0] hfp;
        logic [FW-1:0] vspw;
        logic [FW-1:0] vbp;
        logic [FW-1:0] vact;
        logic [FW-1:0] vfp;
    } vtg_cfg_t;
endpackage

// File: rtl/vtg_shadow.sv
// Shadow-to-active transfer of the configuration record.
// Assumes frame_end is a one-cycle strobe on the last source cycle of a frame.
// The running set is loaded on that strobe, or continuously while stopped,
// unless hold is high.
module vtg_shadow
    import vtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  vtg_cfg_t cfg_in,
    input  logic     hold,
    input  logic     frame_end,
    output vtg_cfg_t act
);
    logic load;

    // Decide whether the running set may take the shadow values this cycle.
    always_comb load = !hold && (frame_end || !act.en);

    // Hold the running set; reset leaves the generator stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)    act <= '0;
        else if (load) act <= cfg_in;
    end

    AST_HOLD_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(act)); // R7
    AST_NO_MIDFRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (act.en && !frame_end) |=> $stable(act)); // R6
endmodule

// File: rtl/vtg_pclk_div.sv
// Pixel clock divider: divides the source clock by div+1.
// Assumes div only changes while the block is stopped or on a pix_en cycle.
// Emits pix_en in the last cycle of each pixel and a raw clock level that is
// high in the upper part of the pixel.
module vtg_pclk_div
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          pix_en,
    output logic          pclk_lvl
);
    logic [DW-1:0] cnt;

    // Pixel strobe and raw clock level from the phase counter.
    always_comb begin
        pix_en   = run && (cnt == div);
        pclk_lvl = run && (cnt > (div >> 1));
    end

    // Phase counter inside one pixel; parked at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (pix_en)    cnt <= '0;
        else                cnt <= cnt + DW'(1);
    end

    AST_PIX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && div != '0) |=> (!pix_en || !$stable(div))); // R4
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pix_en); // R8
endmodule

// File: rtl/vtg_counter.sv
// Horizontal and vertical position counters and region decode.
// Each axis runs sync, back porch, active, front porch; every field is
// stored minus one. The position advances on pix_en. The counters stay at the
// origin while stopped. Also produces the frame-end strobe and the registered
// frame interrupt.
module vtg_counter
    import vtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     pix_en,
    input  vtg_cfg_t cfg,
    output logic     hs_raw,
    output logic     vs_raw,
    output logic     de_raw,
    output logic     frame_end,
    output logic     irq
);
    logic [CW-1:0] h, v, nh, nv;
    logic [CW-1:0] hs_end, ha_beg, ha_end, htot;
    logic [CW-1:0] vs_end, va_beg, va_end, vtot;
    logic [CW-1:0] irq_line;
    logic          h_last, v_last;

    // Region boundaries of both axes from the minus-one fields.
    always_comb begin
        hs_end = CW'(cfg.hspw) + CW'(1);
        ha_beg = hs_end + CW'(cfg.hbp) + CW'(1);
        ha_end = ha_beg + CW'(cfg.hact) + CW'(1);
        htot   = ha_end + CW'(cfg.hfp) + CW'(1);
        vs_end = CW'(cfg.vspw) + CW'(1);
        va_beg = vs_end + CW'(cfg.vbp) + CW'(1);
        va_end = va_beg + CW'(cfg.vact) + CW'(1);
        vtot   = va_end + CW'(cfg.vfp) + CW'(1);
    end

    // Next position: step right, wrap to the next line, wrap to the frame top.
    always_comb begin
        h_last = (h == htot - CW'(1));
        v_last = (v == vtot - CW'(1));
        nh = h;
        nv = v;
        if (pix_en) begin
            if (h_last) begin
                nh = '0;
                nv = v_last ? '0 : v + CW'(1);
            end else begin
                nh = h + CW'(1);
            end
        end
        frame_end = run && pix_en && h_last && v_last;
    end

    // Line on which the frame interrupt is raised, by select code.
    always_comb begin
        case (cfg.irq_sel)
            IRQ_FRONT:  irq_line = va_end;
            IRQ_SYNC:   irq_line = '0;
            IRQ_BACK:   irq_line = vs_end;
            default:    irq_line = va_beg;
        endcase
    end

    // Position registers; parked at the origin while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            h <= '0;
            v <= '0;
        end else begin
            h <= nh;
            v <= nv;
        end
    end

    // Interrupt pulse in the first cycle of the selected line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= run && pix_en && (nh == '0) && (nv == irq_line);
    end

    // Region flags, gated by run so a stopped generator is idle.
    always_comb begin
        hs_raw = run && (h < hs_end);
        vs_raw = run && (v < vs_end);
        de_raw = run && (h >= ha_beg) && (h < ha_end) && (v >= va_beg) && (v < va_end);
    end

    AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> (!hs_raw && !vs_raw)); // R3
    AST_IDLE_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (h == '0 && v == '0)); // R8
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
endmodule

// File: rtl/vid_timing_gen.sv
// Top of the RGB panel video timing generator.
// Assumes the cfg_* inputs are static or change only in the source clock
// domain. Shadows the configuration, divides the pixel clock, runs the
// position counters and applies output polarity.
module vid_timing_gen
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic          cfg_hold,
    input  logic [1:0]    cfg_irq_sel,
    input  logic          cfg_inv_vsync,
    input  logic          cfg_inv_hsync,
    input  logic          cfg_inv_de,
    input  logic          cfg_inv_pclk,
    input  logic [DW-1:0] cfg_clk_div,
    input  logic [FW-1:0] cfg_hsync_w,
    input  logic [FW-1:0] cfg_hback,
    input  logic [FW-1:0] cfg_hactive,
    input  logic [FW-1:0] cfg_hfront,
    input  logic [FW-1:0] cfg_vsync_w,
    input  logic [FW-1:0] cfg_vback,
    input  logic [FW-1:0] cfg_vactive,
    input  logic [FW-1:0] cfg_vfront,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pclk,
    output logic          pix_en,
    output logic          frame_irq
);
    vtg_cfg_t shadow_cfg, act_cfg;
    logic     frame_end, pclk_lvl, hs_raw, vs_raw, de_raw;

    // Gather the configuration inputs into the shadow record.
    always_comb begin
        shadow_cfg.en       = cfg_en;
        shadow_cfg.irq_sel  = irq_sel_e'(cfg_irq_sel);
        shadow_cfg.inv_vs   = cfg_inv_vsync;
        shadow_cfg.inv_hs   = cfg_inv_hsync;
        shadow_cfg.inv_de   = cfg_inv_de;
        shadow_cfg.inv_pclk = cfg_inv_pclk;
        shadow_cfg.div      = cfg_clk_div;
        shadow_cfg.hspw     = cfg_hsync_w;
        shadow_cfg.hbp      = cfg_hback;
        shadow_cfg.hact     = cfg_hactive;
        shadow_cfg.hfp      = cfg_hfront;
        shadow_cfg.vspw     = cfg_vsync_w;
        shadow_cfg.vbp      = cfg_vback;
        shadow_cfg.vact     = cfg_vactive;
        shadow_cfg.vfp      = cfg_vfront;
    end

    vtg_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_in    (shadow_cfg),
        .hold      (cfg_hold),
        .frame_end (frame_end),
        .act       (act_cfg)
    );

    vtg_pclk_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (act_cfg.en),
        .div      (act_cfg.div),
        .pix_en   (pix_en),
        .pclk_lvl (pclk_lvl)
    );

    vtg_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (act_cfg.en),
        .pix_en    (pix_en),
        .cfg       (act_cfg),
        .hs_raw    (hs_raw),
        .vs_raw    (vs_raw),
        .de_raw    (de_raw),
        .frame_end (frame_end),
        .irq       (frame_irq)
    );

    // Apply the running polarity to each panel output.
    always_comb begin
        hsync = hs_raw   ^ act_cfg.inv_hs;
        vsync = vs_raw   ^ act_cfg.inv_vs;
        de    = de_raw   ^ act_cfg.inv_de;
        pclk  = pclk_lvl ^ act_cfg.inv_pclk;
    end
endmodule

// File: tb/vid_timing_gen_tb.sv
module vid_timing_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    // div, hspw, hbp, hact, hfp, vspw, vbp, vact, vfp (all minus one)
    localparam int VEC [NV][9] = '{
        '{0, 0, 1, 3, 0, 0, 0, 1, 0},
        '{1, 2, 3, 15, 1, 1, 2, 9, 3},
        '{3, 1, 0, 7, 2, 0, 1, 5, 0},
        '{2, 0, 0, 0, 0, 0, 0, 0, 0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_hold = 1'b0;
    logic [1:0] cfg_irq_sel = 2'd0;
    logic inv_vs = 1'b0, inv_hs = 1'b0, inv_de = 1'b0, inv_pc = 1'b0;
    logic [7:0] cfg_clk_div = '0;
    logic [9:0] f_hspw = '0, f_hbp = '0, f_hact = '0, f_hfp = '0;
    logic [9:0] f_vspw = '0, f_vbp = '0, f_vact = '0, f_vfp = '0;
    logic hsync, vsync, de, pclk, pix_en, frame_irq;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_hold(cfg_hold),
        .cfg_irq_sel(cfg_irq_sel), .cfg_inv_vsync(inv_vs), .cfg_inv_hsync(inv_hs),
        .cfg_inv_de(inv_de), .cfg_inv_pclk(inv_pc), .cfg_clk_div(cfg_clk_div),
        .cfg_hsync_w(f_hspw), .cfg_hback(f_hbp), .cfg_hactive(f_hact), .cfg_hfront(f_hfp),
        .cfg_vsync_w(f_vspw), .cfg_vback(f_vbp), .cfg_vactive(f_vact), .cfg_vfront(f_vfp),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk(pclk), .pix_en(pix_en),
        .frame_irq(frame_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_vec(input int i);
        cfg_clk_div = 8'(VEC[i][0]);
        f_hspw = 10'(VEC[i][1]); f_hbp = 10'(VEC[i][2]);
        f_hact = 10'(VEC[i][3]); f_hfp = 10'(VEC[i][4]);
        f_vspw = 10'(VEC[i][5]); f_vbp = 10'(VEC[i][6]);
        f_vact = 10'(VEC[i][7]); f_vfp = 10'(VEC[i][8]);
    endtask

    function automatic int htot(input int i);
        return VEC[i][1] + VEC[i][2] + VEC[i][3] + VEC[i][4] + 4;
    endfunction
    function automatic int vtot(input int i);
        return VEC[i][5] + VEC[i][6] + VEC[i][7] + VEC[i][8] + 4;
    endfunction
    function automatic int period(input int i);
        return htot(i) * vtot(i) * (VEC[i][0] + 1);
    endfunction

    // Wait, sampling on the falling edge, for vertical sync to turn active.
    task automatic wait_vs_rise();
        logic prev, cur;
        prev = vsync ^ inv_vs;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            cur = vsync ^ inv_vs;
            if (cur && !prev) return;
            prev = cur;
        end
    endtask

    // Measure one frame from a vsync rise to the next one.
    task automatic measure(output int per, output int dec, output int hsc, output int vsc,
                           output int pcc, output int irqn, output int irqoff);
        logic prev, cur;
        per = 0; dec = 0; hsc = 0; vsc = 0; pcc = 0; irqn = 0; irqoff = -1;
        wait_vs_rise();
        prev = 1'b1;
        for (int k = 0; k < 5000; k++) begin
            cur = vsync ^ inv_vs;
            if (cur && !prev) break;
            prev = cur;
            per++;
            if (de ^ inv_de) dec++;
            if (hsync ^ inv_hs) hsc++;
            if (cur) vsc++;
            if (pclk) pcc++;
            if (frame_irq) begin irqn++; irqoff = k; end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int per, dec, hsc, vsc, pcc, irqn, irqoff, F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state, generator stopped
        check("R10 hsync", int'(hsync), 0);
        check("R10 vsync", int'(vsync), 0);
        check("R10 de", int'(de), 0);
        check("R10 pclk", int'(pclk), 0);
        check("R10 pix_en", int'(pix_en), 0);

        // Vector walk: R1 R2 R3 R4 R9 under several timings
        cfg_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            set_vec(i);
            F = VEC[i][0] + 1;
            wait_vs_rise();
            wait_vs_rise();
            measure(per, dec, hsc, vsc, pcc, irqn, irqoff);
            check("R2 frame period", per, period(i));
            check("R2 vsync width", vsc, (VEC[i][5] + 1) * htot(i) * F);
            check("R1 hsync width", hsc, (VEC[i][1] + 1) * vtot(i) * F);
            check("R3 de count", dec, (VEC[i][3] + 1) * (VEC[i][7] + 1) * F);
            check("R4 pclk high", pcc, htot(i) * vtot(i) * (VEC[i][0] - (VEC[i][0] >> 1)));
            check("R9 front porch irq offset", irqoff,
                  (VEC[i][5] + VEC[i][6] + VEC[i][7] + 3) * htot(i) * F);
        end

        // R9: other interrupt points on vector 1
        set_vec(1);
        for (int s = 1; s < 4; s++) begin
            int exp_off;
            cfg_irq_sel = 2'(s);
            wait_vs_rise();
            wait_vs_rise();
            measure(per, dec, hsc, vsc, pcc, irqn, irqoff);
            exp_off = (s == 1) ? 0 : (s == 2) ? (VEC[1][5] + 1) * htot(1) * 2
                                              : (VEC[1][5] + VEC[1][6] + 2) * htot(1) * 2;
            check("R9 irq count", irqn, 1);
            check("R9 irq offset", irqoff, exp_off);
        end
        cfg_irq_sel = 2'd0;

        // R5: all polarities inverted on vector 2
        set_vec(2);
        inv_vs = 1'b1; inv_hs = 1'b1; inv_de = 1'b1; inv_pc = 1'b1;
        wait_vs_rise(); wait_vs_rise(); wait_vs_rise();
        measure(per, dec, hsc, vsc, pcc, irqn, irqoff);
        check("R5 inverted period", per, period(2));
        check("R5 inverted vsync", vsc, (VEC[2][5] + 1) * htot(2) * 4);
        check("R5 inverted hsync", hsc, (VEC[2][1] + 1) * vtot(2) * 4);
        check("R5 inverted de", dec, (VEC[2][3] + 1) * (VEC[2][7] + 1) * 4);
        check("R5 inverted pclk", pcc, period(2) - htot(2) * vtot(2) * 2);
        inv_vs = 1'b0; inv_hs = 1'b0; inv_de = 1'b0; inv_pc = 1'b0;

        // R6: a change in the middle of a frame leaves that frame alone
        set_vec(1);
        wait_vs_rise(); wait_vs_rise(); wait_vs_rise();
        wait_vs_rise();
        begin
            logic prev, cur;
            int n;
            prev = 1'b1; n = 0;
            for (int k = 0; k < 5000; k++) begin
                cur = vsync;
                if (cur && !prev) break;
                prev = cur;
                n++;
                if (k == 10) set_vec(0);
                @(negedge clk);
            end
            check("R6 current frame kept", n, period(1));
        end
        measure(per, dec, hsc, vsc, pcc, irqn, irqoff);
        check("R6 next frame new", per, period(0));

        // R7: hold keeps the running set; release applies at the next boundary
        cfg_hold = 1'b1;
        set_vec(3);
        wait_vs_rise(); wait_vs_rise();
        measure(per, dec, hsc, vsc, pcc, irqn, irqoff);
        check("R7 held period", per, period(0));
        cfg_hold = 1'b0;
        wait_vs_rise(); wait_vs_rise();
        measure(per, dec, hsc, vsc, pcc, irqn, irqoff);
        check("R7 released period", per, period(3));

        // R8: disable finishes the current frame, then idles
        set_vec(0);
        wait_vs_rise(); wait_vs_rise(); wait_vs_rise();
        cfg_en = 1'b0;
        begin
            int nde, nrise;
            logic prev, cur;
            nde = 0; nrise = 0; prev = 1'b1;
            for (int k = 0; k < 3 * period(0); k++) begin
                cur = vsync;
                if (cur && !prev) nrise++;
                prev = cur;
                if (de) nde++;
                @(negedge clk);
            end
            check("R8 last frame de", nde, (VEC[0][3] + 1) * (VEC[0][7] + 1));
            check("R8 no new frame", nrise, 0);
            check("R8 idle sync/strobe", int'({vsync, hsync, pix_en}), 0);
        end
        // R8: restart from stopped begins a frame on the next cycle
        cfg_en = 1'b1;
        @(negedge clk);
        check("R8 restart vsync", int'(vsync), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule